// File: doc/BRIEF.md
# Serial Pattern Recognizer with Lockout

This block watches a serial bit stream, taking one bit on every rising clock edge. It raises its match output whenever the three most recent bits are 0, 1, 0 in arrival order. It does so only while the sequence 1, 0, 0 has not yet occurred since the last reset. Once 1, 0, 0 has arrived, the block enters a permanent lockout. The output then stays low until the next reset.

The recognizer is a Moore machine. The output is decoded from the state register alone, so it appears in the clock cycle after the edge that sampled the third bit of the pattern. Its states keep track of shared prefixes: after "...01", a 0 completes the target pattern. After "...10", a 0 completes the lockout pattern and a 1 gives the prefix "...01". After a match, a 1 gives "...01" again, which makes overlapping matches work.

Top module: `patrec_lockout`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the machine returns to its initial state, and match_o is 0 in the cycle after that edge.
- R2: When the last three bits sampled since reset are 0,1,0 (oldest first) and 1,0,0 has never been sampled since reset, match_o is 1 in the cycle after the edge that sampled the final 0. In every other case it is 0.
- R3: Overlapping matches are detected. After a match, the input 1 followed by 0 gives a second match, so 01010 gives match_o high after bit 3 and after bit 5.
- R4: Once the bits 1,0,0 have been sampled in a row since reset, match_o stays 0 on every later cycle until reset, whatever the input.
- R5: A reset after lockout brings back normal detection. The first 0,1,0 after reset gives a match.
- R6: Runs of repeated bits do not disturb detection. Any number of leading 0s followed by 1,0 gives a match. A run of 1s followed by 0,1,0 without an intervening 0,0 also gives a match.
- R7: The input stream 00101010010 gives the output stream 00010101000, and the stream 11011010010 gives 00000001000, each output bit being the value after the edge that sampled the matching input bit.
- R8: match_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one bit is sampled per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | 1 | Serial data bit |
| match_o | output | 1 | Registered match flag, high for one cycle per detected 0,1,0 |

## Verification
Every result is due exactly one clock edge after the bit that completes it. The state register is the only register between din_i and match_o. The bench therefore drives each bit at a falling edge and compares match_o at the next falling edge, after the rising edge that sampled the bit. The reference model updates its history and its sticky lockout flag at that same rising edge. The two fixed streams, the overlap, lockout and recovery cases and a long random stream with occasional resets are each compared bit by bit on that one-cycle schedule.

// File: rtl/patrec_pkg.sv
package patrec_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_ZERO     = 3'd1,
        ST_ZERO_ONE = 3'd2,
        ST_HIT      = 3'd3,
        ST_ONE      = 3'd4,
        ST_ONE_ZERO = 3'd5,
        ST_LOCK     = 3'd6
    } rec_state_t;

    // Next state for one sampled bit. The unused encoding falls back to idle.
    function automatic rec_state_t step_state(input rec_state_t cur, input logic bit_in);
        rec_state_t nxt;
        case (cur)
            ST_IDLE:     nxt = bit_in ? ST_ONE      : ST_ZERO;
            ST_ZERO:     nxt = bit_in ? ST_ZERO_ONE : ST_ZERO;
            ST_ZERO_ONE: nxt = bit_in ? ST_ONE      : ST_HIT;
            ST_HIT:      nxt = bit_in ? ST_ZERO_ONE : ST_LOCK;
            ST_ONE:      nxt = bit_in ? ST_ONE      : ST_ONE_ZERO;
            ST_ONE_ZERO: nxt = bit_in ? ST_ZERO_ONE : ST_LOCK;
            ST_LOCK:     nxt = ST_LOCK;
            default:     nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic is_hit(input rec_state_t cur);
        return (cur == ST_HIT);
    endfunction

endpackage

// File: rtl/patrec_next.sv
module patrec_next
    import patrec_pkg::*;
(
    input  rec_state_t cur_i,
    input  logic       din_i,
    output rec_state_t nxt_o
);
    always_comb begin
        nxt_o = step_state(cur_i, din_i);
    end
endmodule

// File: rtl/patrec_state_reg.sv
module patrec_state_reg
    import patrec_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  rec_state_t nxt_i,
    output rec_state_t cur_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) cur_o <= ST_IDLE;
        else       cur_o <= nxt_i;
    end
endmodule

// File: rtl/patrec_out.sv
module patrec_out
    import patrec_pkg::*;
(
    input  rec_state_t cur_i,
    output logic       match_o
);
    always_comb begin
        match_o = is_hit(cur_i);
    end
endmodule

// File: rtl/patrec_lockout.sv
module patrec_lockout
    import patrec_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic match_o
);
    rec_state_t state_q;
    rec_state_t state_d;

    patrec_next u_next (
        .cur_i (state_q),
        .din_i (din_i),
        .nxt_o (state_d)
    );

    patrec_state_reg u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .nxt_i (state_d),
        .cur_o (state_q)
    );

    patrec_out u_out (
        .cur_i   (state_q),
        .match_o (match_o)
    );
endmodule

// File: rtl/patrec_lockout_chk.sv
module patrec_lockout_chk (
    input logic clk_i,
    input logic rst_i,
    input logic din_i,
    input logic match_o
);
    logic [2:0] hist_q;
    logic [1:0] fill_q;
    logic       seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hist_q <= 3'b000;
            fill_q <= 2'd0;
            seen_q <= 1'b0;
        end else begin
            hist_q <= {hist_q[1:0], din_i};
            if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
            if ({hist_q[1:0], din_i} == 3'b100 && fill_q >= 2'd2) seen_q <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> !match_o); // R1

    AST_MATCH_ON_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_q == 2'd3 && hist_q == 3'b010 && !seen_q) |-> match_o); // R2

    AST_NO_FALSE_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |-> (fill_q == 2'd3 && hist_q == 3'b010)); // R2

    AST_OVERLAP_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_o && din_i) ##1 !din_i |=> match_o); // R3

    AST_LOCK_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_q |-> !match_o); // R4

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |=> !match_o); // R8
endmodule

bind patrec_lockout patrec_lockout_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .din_i   (din_i),
    .match_o (match_o)
);

// File: tb/patrec_lockout_bench.sv
`timescale 1ns/1ps
module patrec_lockout_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic match;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    bit hist[$];
    bit seen = 1'b0;

    always #2 clk = ~clk;

    patrec_lockout u_patrec_lockout (
        .clk_i   (clk),
        .rst_i   (rst),
        .din_i   (din),
        .match_o (match)
    );

    task automatic check(input logic exp, input string req);
        vectors++;
        if (match !== exp) begin
            miscompares++;
            $display("FAIL %s: match_o=%b expected %b at %0t", req, match, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist.delete();
        seen = 1'b0;
        check(1'b0, "R1");
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic send(input bit b, input string req, output logic exp);
        din = b;
        @(posedge clk);
        hist.push_back(b);
        if (hist.size() > 3) void'(hist.pop_front());
        if (hist.size() == 3 && hist[0] == 1 && hist[1] == 0 && hist[2] == 0) seen = 1'b1;
        exp = (hist.size() == 3 && hist[0] == 0 && hist[1] == 1 && hist[2] == 0 && !seen);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic send_stream(input string bits, input string req);
        logic e;
        for (int i = 0; i < bits.len(); i++) send(bits[i] == "1", req, e);
    endtask

    // Checks a stream against an explicit expected output string (R7).
    task automatic send_fixed(input string bits, input string outs);
        logic e;
        for (int i = 0; i < bits.len(); i++) begin
            send(bits[i] == "1", "R7", e);
            vectors++;
            if (match !== (outs[i] == "1")) begin
                miscompares++;
                $display("FAIL R7: bit %0d match_o=%b expected %s", i, match, outs.substr(i, i));
            end
        end
    endtask

    initial begin
        logic e;
        logic prev;
        @(negedge clk);
        do_reset();                                  // R1

        send_fixed("00101010010", "00010101000");    // R7
        do_reset();
        send_fixed("11011010010", "00000001000");    // R7
        do_reset();

        send_stream("010", "R2");                    // R2 single match
        send_stream("10", "R3");                     // R3 overlapping second match
        send_stream("0", "R4");                      // completes 100
        send_stream("0101010101", "R4");             // R4 stays silent
        do_reset();                                  // R5 recovery
        send_stream("010", "R5");
        do_reset();
        send_stream("00000010", "R6");               // R6 leading zeros
        do_reset();
        send_stream("1111010", "R6");                // R6 run of ones
        do_reset();

        // R8 and R2 on a random stream with occasional resets
        prev = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 299) == 0) begin
                do_reset();
                prev = 1'b0;
            end
            send($urandom_range(0, 3) != 0 ? bit'($urandom_range(0, 1)) : 1'b0, "R2", e);
            vectors++;
            if (prev && match) begin
                miscompares++;
                $display("FAIL R8: match_o=1 expected 0 after a high cycle");
            end
            prev = match;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule